// File: doc/BRIEF.md
# Interval Timer Channel

This block is one channel of a timer peripheral, reached through a plain 32-bit register port with an address, a write strobe, write data and combinational read data. An up-counter advances on count ticks. A tick comes on every clock, or, when the divider is switched on, once every `2 << d` clocks, where `d` is the divider field. In interval mode the counter is compared against compare register A. A match latches a status flag, which can drive the interrupt line.

When the zero-clear option is on, the counter restarts from zero after each match. The channel then gives a periodic tick of `A + 1` counts. When the option is off, the counter runs through the match and keeps going, so a single programmed delay gives exactly one event. That is the one-shot use. The live count can be read at any time, so a second channel left running with no interrupt works as a continuous time base.

The other mode encodings, the second compare register and the two auxiliary mode words are held and can be read back, but they have no effect.

Top module: `tmr_channel`

## Requirements
- R1: After reset, the registers read as follows: control 0x20, compare A all ones in CNT_W bits, count 0, and every other register 0. The interrupt output is low.
- R2: The register offsets are control 0x00, status 0x04, compare A 0x08, compare B 0x0C, interval option 0x10, divider 0x20, auxiliary words 0x30 and 0x40, and count 0x40+0xB0=0xF0. Control keeps bits 7,6,5,3,2,1:0 (readback mask 0xEF). Compare A and B keep the low CNT_W bits. The interval option keeps bit 15 (interrupt enable) and bit 0 (zero-clear). The divider keeps the low DIV_W bits. The auxiliary words keep all 32 bits.
- R3: Unmapped offsets read as 0 and ignore writes. Writes to the count register are ignored.
- R4: With control bit 7 (run) set, mode bits 1:0 = 0 (interval) and bit 6 (divider enable) clear, the count advances by one on every clock edge after the control write takes effect.
- R5: With bit 6 set and divider field d, the count advances once every 2<<d clocks.
- R6: While run is clear, the count holds if bit 5 (clear-on-stop) is clear. If bit 5 is set, the count is forced to 0 on the next edge.
- R7: Status bit 0 is set on the count tick that brings the counter equal to compare A.
- R8: With zero-clear on, the tick after a match loads 0, so matches repeat every A+1 ticks.
- R9: With zero-clear off, the counter counts past compare A and wraps at CNT_W bits. No further match occurs until the value comes round again.
- R10: Writing status with bit 0 = 0 clears the flag, and writing 1 leaves it unchanged. A new match in the same cycle wins over the clear.
- R11: The interrupt output is high exactly when status bit 0 and interval bit 15 are both set.
- R12: Mode values 1, 2 and 3 are reserved. In a reserved mode the counter does not advance and no match is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and timer clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_we | input | 1 | Write strobe, sampled at the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| irq | output | 1 | Interval interrupt request, level |

## Verification
The bench builds the channel with CNT_W = 24, DIV_W = 3 and ADDR_W = 8. A 24-bit counter makes the truncation of compare A and B visible on readback. A 3-bit divider field allows ratios from 2 to 256, and the bench walks the three smallest of them and checks the masked field. With these values a full 2^24 wrap is out of reach of a short run, so the increment-with-wrap rule is carried by a property on every tick. Match timing, zero-clear period, the one-shot use and the reserved modes are all reached with small compare values.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

   localparam int unsigned MAP_AW = 8;

   // register offsets
   localparam logic [7:0] A_CTRL = 8'h00;
   localparam logic [7:0] A_STAT = 8'h04;
   localparam logic [7:0] A_CMPA = 8'h08;
   localparam logic [7:0] A_CMPB = 8'h0C;
   localparam logic [7:0] A_ITVL = 8'h10;
   localparam logic [7:0] A_DIV  = 8'h20;
   localparam logic [7:0] A_PGEN = 8'h30;
   localparam logic [7:0] A_WDOG = 8'h40;
   localparam logic [7:0] A_CNT  = 8'hF0;

   // auxiliary (stored, inert) mode words
   localparam int unsigned N_AUX = 2;
   localparam logic [N_AUX*8-1:0] AUX_OFFS = {A_WDOG, A_PGEN};

   // interval option bits
   localparam int unsigned ITVL_IE_B = 15;
   localparam int unsigned ITVL_ZC_B = 0;

   typedef enum logic [1:0] {
      MODE_INTERVAL = 2'd0,
      MODE_PULSE    = 2'd1,
      MODE_GUARD    = 2'd2,
      MODE_RSVD     = 2'd3
   } tmr_mode_e;

   typedef struct packed {
      logic      run_en;
      logic      div_en;
      logic      clr_en;
      logic      edge_sel;
      logic      src_sel;
      tmr_mode_e mode;
   } tmr_ctrl_t;

   localparam tmr_ctrl_t CTRL_RST = '{run_en: 1'b0, div_en: 1'b0, clr_en: 1'b1,
                                      edge_sel: 1'b0, src_sel: 1'b0,
                                      mode: MODE_INTERVAL};

   function automatic tmr_ctrl_t ctrl_unpack(input logic [31:0] w);
      tmr_ctrl_t c;
      c.run_en   = w[7];
      c.div_en   = w[6];
      c.clr_en   = w[5];
      c.edge_sel = w[3];
      c.src_sel  = w[2];
      c.mode     = tmr_mode_e'(w[1:0]);
      return c;
   endfunction

   function automatic logic [31:0] ctrl_pack(input tmr_ctrl_t c);
      return {24'b0, c.run_en, c.div_en, c.clr_en, 1'b0, c.edge_sel, c.src_sel, c.mode};
   endfunction

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
   parameter int DIV_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             clr,
   input  logic             div_en,
   input  logic [DIV_W-1:0] div_sel,
   output logic             tick
);
   localparam int PRE_W = (2 ** DIV_W) + 1;

   logic [PRE_W-1:0] div_cnt;
   logic [PRE_W:0]   one_sh;
   logic [PRE_W-1:0] lim;
   logic             wrap;

   always_comb begin
      one_sh = (PRE_W+1)'(1) << (int'(div_sel) + 1);
      lim    = PRE_W'(one_sh - 1'b1);
      wrap   = (div_cnt >= lim);
   end

   assign tick = run & (~div_en | wrap);

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         div_cnt <= '0;
      end else if (run) begin
         if (!div_en || wrap) div_cnt <= '0;
         else                 div_cnt <= div_cnt + 1'b1;
      end
   end

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
   parameter int CNT_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             clr,
   input  logic             zc_en,
   input  logic [CNT_W-1:0] cmp,
   output logic [CNT_W-1:0] count,
   output logic             hit
);
   logic [CNT_W-1:0] nxt;

   always_comb begin
      if (zc_en && (count == cmp)) nxt = '0;
      else                         nxt = count + 1'b1;
   end

   assign hit = tick & (nxt == cmp);

   always_ff @(posedge clk) begin
      if (!rst_n || clr) count <= '0;
      else if (tick)     count <= nxt;
   end

endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
   import tmr_pkg::*;
#(
   parameter int CNT_W  = 24,
   parameter int DIV_W  = 3,
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic [CNT_W-1:0]  count,
   input  logic              hit,
   output logic              run_en,
   output logic              div_en,
   output logic              clr_en,
   output logic [1:0]        mode,
   output logic [CNT_W-1:0]  cmp_a,
   output logic              zc_en,
   output logic              iie,
   output logic [DIV_W-1:0]  div_sel,
   output logic              flag
);
   logic       map_ok;
   logic [7:0] off;

   generate
      if (ADDR_W > MAP_AW) begin : g_hi_dec
         assign map_ok = ~|bus_addr[ADDR_W-1:MAP_AW];
      end else begin : g_no_hi
         assign map_ok = 1'b1;
      end
   endgenerate

   assign off = bus_addr[7:0];

   logic wr_ctrl, wr_stat, wr_cmpa, wr_cmpb, wr_itvl, wr_div;
   assign wr_ctrl = bus_we & map_ok & (off == A_CTRL);
   assign wr_stat = bus_we & map_ok & (off == A_STAT);
   assign wr_cmpa = bus_we & map_ok & (off == A_CMPA);
   assign wr_cmpb = bus_we & map_ok & (off == A_CMPB);
   assign wr_itvl = bus_we & map_ok & (off == A_ITVL);
   assign wr_div  = bus_we & map_ok & (off == A_DIV);

   tmr_ctrl_t        ctrl_q;
   logic [CNT_W-1:0] cmp_b;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q  <= CTRL_RST;
         cmp_a   <= '1;
         cmp_b   <= '0;
         zc_en   <= 1'b0;
         iie     <= 1'b0;
         div_sel <= '0;
      end else begin
         if (wr_ctrl) ctrl_q  <= ctrl_unpack(bus_wdata);
         if (wr_cmpa) cmp_a   <= bus_wdata[CNT_W-1:0];
         if (wr_cmpb) cmp_b   <= bus_wdata[CNT_W-1:0];
         if (wr_itvl) begin
            zc_en <= bus_wdata[ITVL_ZC_B];
            iie   <= bus_wdata[ITVL_IE_B];
         end
         if (wr_div)  div_sel <= bus_wdata[DIV_W-1:0];
      end
   end

   // interval flag: a new match outranks a software clear
   always_ff @(posedge clk) begin
      if (!rst_n)                        flag <= 1'b0;
      else if (hit)                      flag <= 1'b1;
      else if (wr_stat && !bus_wdata[0]) flag <= 1'b0;
   end

   // auxiliary mode words: kept for readback only
   logic [31:0] aux_q [N_AUX];

   generate
      for (genvar g = 0; g < N_AUX; g++) begin : g_aux
         logic wr_this;
         assign wr_this = bus_we & map_ok & (off == AUX_OFFS[g*8 +: 8]);
         always_ff @(posedge clk) begin
            if (!rst_n)       aux_q[g] <= '0;
            else if (wr_this) aux_q[g] <= bus_wdata;
         end
      end
   endgenerate

   assign run_en = ctrl_q.run_en;
   assign div_en = ctrl_q.div_en;
   assign clr_en = ctrl_q.clr_en;
   assign mode   = ctrl_q.mode;

   always_comb begin
      bus_rdata = '0;
      if (map_ok) begin
         case (off)
            A_CTRL:  bus_rdata = ctrl_pack(ctrl_q);
            A_STAT:  bus_rdata = {29'b0, 2'b00, flag};
            A_CMPA:  bus_rdata = 32'(cmp_a);
            A_CMPB:  bus_rdata = 32'(cmp_b);
            A_ITVL:  bus_rdata = {16'b0, iie, 14'b0, zc_en};
            A_DIV:   bus_rdata = 32'(div_sel);
            A_CNT:   bus_rdata = 32'(count);
            default: bus_rdata = '0;
         endcase
         for (int i = 0; i < int'(N_AUX); i++) begin
            if (off == AUX_OFFS[i*8 +: 8]) bus_rdata = aux_q[i];
         end
      end
   end

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
   import tmr_pkg::*;
#(
   parameter int CNT_W  = 24,
   parameter int DIV_W  = 3,
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              irq
);
   generate
      if (!(CNT_W == 24 || CNT_W == 32)) begin : g_bad_cnt_w
         $error("tmr_channel: CNT_W must be 24 or 32");
      end
      if (DIV_W < 1 || DIV_W > 4) begin : g_bad_div_w
         $error("tmr_channel: DIV_W must lie in 1..4");
      end
      if (ADDR_W < int'(MAP_AW)) begin : g_bad_addr_w
         $error("tmr_channel: ADDR_W must cover the 8-bit map");
      end
   endgenerate

   logic             run_en, div_en, clr_en, zc_en, iie, flag;
   logic [1:0]       mode;
   logic [CNT_W-1:0] cmp_a, count;
   logic [DIV_W-1:0] div_sel;
   logic             run, clr, tick, hit;

   assign run = run_en & (mode == MODE_INTERVAL);
   assign clr = ~run_en & clr_en;

   tmr_regs #(.CNT_W(CNT_W), .DIV_W(DIV_W), .ADDR_W(ADDR_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .bus_addr (bus_addr),
      .bus_we   (bus_we),
      .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata),
      .count    (count),
      .hit      (hit),
      .run_en   (run_en),
      .div_en   (div_en),
      .clr_en   (clr_en),
      .mode     (mode),
      .cmp_a    (cmp_a),
      .zc_en    (zc_en),
      .iie      (iie),
      .div_sel  (div_sel),
      .flag     (flag)
   );

   tmr_prescaler #(.DIV_W(DIV_W)) u_pre (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (run),
      .clr    (clr),
      .div_en (div_en),
      .div_sel(div_sel),
      .tick   (tick)
   );

   tmr_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk  (clk),
      .rst_n(rst_n),
      .tick (tick),
      .clr  (clr),
      .zc_en(zc_en),
      .cmp  (cmp_a),
      .count(count),
      .hit  (hit)
   );

   assign irq = flag & iie;

endmodule

// File: rtl/tmr_channel_chk.sv
module tmr_channel_chk
   import tmr_pkg::*;
#(
   parameter int CNT_W  = 24,
   parameter int ADDR_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_we,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              wd0,
   input logic              irq,
   input logic              tick,
   input logic              run_en,
   input logic              clr_en,
   input logic [1:0]        mode,
   input logic              zc_en,
   input logic              iie,
   input logic              flag,
   input logic [CNT_W-1:0]  cmp_a,
   input logic [CNT_W-1:0]  count
);
   logic stop_clr, stat_clr;
   assign stop_clr = !run_en && clr_en;
   assign stat_clr = bus_we && (bus_addr == ADDR_W'(A_STAT)) && !wd0;

   // R6: clear-on-stop drives the count to zero
   a_r6_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
      stop_clr |=> (count == '0));

   // R4: the count moves only on a prescaler tick
   a_r4_step_only_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !stop_clr) |=> $stable(count));

   // R12: reserved modes freeze the counter
   a_r12_rsvd_mode_holds: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode != 2'd0) && !stop_clr) |=> $stable(count));

   // R8: zero-clear after a match
   a_r8_zero_after_match: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && zc_en && (count == cmp_a)) |=> (count == '0));

   // R9: otherwise a tick adds one, wrapping at CNT_W bits
   a_r9_plus_one: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !(zc_en && (count == cmp_a))) |=> (count == CNT_W'($past(count) + 1'b1)));

   // R7: reaching compare A by a tick leaves the flag set
   a_r7_flag_on_match: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(tick) && $stable(cmp_a) && (count == cmp_a)) |-> flag);

   // R10: the flag only drops on a zero write to status
   a_r10_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !stat_clr) |=> flag);

   // R11: the request line needs both flag and enable
   a_r11_irq_needs_both: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (flag && iie));

endmodule

bind tmr_channel tmr_channel_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .bus_we  (bus_we),
   .bus_addr(bus_addr),
   .wd0     (bus_wdata[0]),
   .irq     (irq),
   .tick    (tick),
   .run_en  (run_en),
   .clr_en  (clr_en),
   .mode    (mode),
   .zc_en   (zc_en),
   .iie     (iie),
   .flag    (flag),
   .cmp_a   (cmp_a),
   .count   (count)
);

// File: tb/tb_tmr_channel.sv
module tb_tmr_channel;
   import tmr_pkg::*;

   localparam int CNT_W  = 24;
   localparam int DIV_W  = 3;
   localparam int ADDR_W = 8;
   localparam int WD_CYC = 200000;

   logic              clk = 1'b0;
   logic              rst_n;
   logic [ADDR_W-1:0] bus_addr;
   logic              bus_we;
   logic [31:0]       bus_wdata;
   logic [31:0]       bus_rdata;
   logic              irq;

   int n_run  = 0;
   int n_fail = 0;

   always #10 clk = ~clk;

   tmr_channel #(.CNT_W(CNT_W), .DIV_W(DIV_W), .ADDR_W(ADDR_W)) dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
   );

   // {reserved-offset flag, offset, write data, expected readback}
   localparam logic [72:0] VEC [10] = '{
      {1'b0, 8'h0C, 32'hA5A5A5A5, 32'h00A5A5A5},
      {1'b0, 8'h08, 32'h12FEDCBA, 32'h00FEDCBA},
      {1'b0, 8'h10, 32'hFFFFFFFF, 32'h00008001},
      {1'b0, 8'h20, 32'hFFFFFFFF, 32'h00000007},
      {1'b0, 8'h30, 32'h12345678, 32'h12345678},
      {1'b0, 8'h40, 32'hCAFEF00D, 32'hCAFEF00D},
      {1'b1, 8'h14, 32'hFFFFFFFF, 32'h00000000},
      {1'b1, 8'hF0, 32'h00001234, 32'h00000000},
      {1'b1, 8'hFC, 32'hFFFFFFFF, 32'h00000000},
      {1'b0, 8'h00, 32'hFFFFFFFF, 32'h000000EF}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      bus_addr  = a;
      bus_wdata = d;
      bus_we    = 1'b1;
      @(posedge clk);
      @(negedge clk);
      bus_we    = 1'b0;
   endtask

   task automatic rdchk(input string req, input logic [7:0] a, input logic [31:0] exp);
      bus_addr = a;
      #1;
      chk(req, bus_rdata, exp);
   endtask

   task automatic tk(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic reinit();
      wr(A_CTRL, 32'h20);
      wr(A_STAT, 32'h0);
      wr(A_DIV,  32'h0);
      wr(A_ITVL, 32'h0);
      wr(A_CMPA, 32'h00FFFFFF);
   endtask

   initial begin
      #(WD_CYC * 20);
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual still running, expected finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rdchk("R1 ctrl", A_CTRL, 32'h20);
      rdchk("R1 cmpA", A_CMPA, 32'h00FFFFFF);
      rdchk("R1 cmpB", A_CMPB, 32'h0);
      rdchk("R1 stat", A_STAT, 32'h0);
      rdchk("R1 itvl", A_ITVL, 32'h0);
      rdchk("R1 div",  A_DIV,  32'h0);
      rdchk("R1 count", A_CNT, 32'h0);
      chk("R1 irq", {31'b0, irq}, 32'h0);

      // R2 / R3 register table
      for (int i = 0; i < 10; i++) begin
         wr(VEC[i][71:64], VEC[i][63:32]);
         rdchk(VEC[i][72] ? "R3 table" : "R2 table", VEC[i][71:64], VEC[i][31:0]);
      end

      // R12 control now holds run with mode 3: counter must stay put
      tk(10);
      rdchk("R12 mode3 count", A_CNT, 32'h0);
      rdchk("R12 mode3 stat", A_STAT, 32'h0);

      // R4 undivided counting
      reinit();
      wr(A_CTRL, 32'h80);
      tk(10);
      rdchk("R4 count rate", A_CNT, 32'd10);

      // R6 stop without clear holds, stop with clear zeroes
      wr(A_CTRL, 32'h00);
      rdchk("R6 stop", A_CNT, 32'd11);
      tk(5);
      rdchk("R6 hold", A_CNT, 32'd11);
      wr(A_CTRL, 32'h20);
      rdchk("R6 pre-clear", A_CNT, 32'd11);
      tk(1);
      rdchk("R6 cleared", A_CNT, 32'd0);

      // R5 divider ratios 2, 4, 8
      for (int d = 0; d < 3; d++) begin
         reinit();
         wr(A_DIV, 32'(d));
         wr(A_CTRL, 32'hC0);
         tk(10 * (2 << d));
         rdchk("R5 divided", A_CNT, 32'd10);
         tk((2 << d) - 1);
         rdchk("R5 before step", A_CNT, 32'd10);
         tk(1);
         rdchk("R5 step", A_CNT, 32'd11);
      end

      // R7 R8 R10 R11 periodic with smallest delay
      reinit();
      wr(A_CMPA, 32'hF);
      wr(A_ITVL, 32'h8001);
      wr(A_CTRL, 32'h80);
      tk(14);
      rdchk("R7 before match", A_STAT, 32'h0);
      chk("R11 idle", {31'b0, irq}, 32'h0);
      tk(1);
      rdchk("R7 match", A_STAT, 32'h1);
      rdchk("R7 count at match", A_CNT, 32'hF);
      chk("R11 raised", {31'b0, irq}, 32'h1);
      tk(1);
      rdchk("R8 zero clear", A_CNT, 32'h0);
      wr(A_STAT, 32'hFFFFFFFF);
      rdchk("R10 write one keeps", A_STAT, 32'h1);
      wr(A_STAT, 32'h0);
      rdchk("R10 write zero clears", A_STAT, 32'h0);
      chk("R11 dropped", {31'b0, irq}, 32'h0);
      tk(12);
      rdchk("R8 not yet", A_STAT, 32'h0);
      tk(1);
      rdchk("R8 period", A_STAT, 32'h1);

      // R11 enable masks the request
      wr(A_ITVL, 32'h0001);
      rdchk("R11 flag kept", A_STAT, 32'h1);
      chk("R11 masked", {31'b0, irq}, 32'h0);
      wr(A_ITVL, 32'h8001);
      chk("R11 unmasked", {31'b0, irq}, 32'h1);

      // R9 one-shot: no zero-clear
      reinit();
      wr(A_CMPA, 32'h5);
      wr(A_ITVL, 32'h8000);
      wr(A_CTRL, 32'h80);
      tk(5);
      rdchk("R9 match", A_STAT, 32'h1);
      tk(3);
      rdchk("R9 runs past", A_CNT, 32'd8);
      wr(A_STAT, 32'h0);
      tk(20);
      rdchk("R9 single event", A_STAT, 32'h0);
      rdchk("R9 count", A_CNT, 32'd29);

      // R12 mode 2 with compare 0
      reinit();
      wr(A_CMPA, 32'h0);
      wr(A_CTRL, 32'h82);
      tk(10);
      rdchk("R12 mode2 count", A_CNT, 32'h0);
      rdchk("R12 mode2 stat", A_STAT, 32'h0);

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule